// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

A first-in first-out buffer whose write side and read side each run on their own clock. Each side keeps a binary pointer with one extra wrap bit. That pointer is turned into Gray code in a register, and the registered value crosses to the other side through a chain of flip-flops. Each direction's chain depth is a parameter from 2 to 5. Empty and almost-empty are worked out on the read clock, from the local read pointer and the synchronized write pointer. Full and almost-full are worked out on the write clock in the mirror-image way. Because of the synchronizers, each flag lags the true occupancy by the depth of its chain.

When `SINGLE_CLK` is set, the read side runs on the write clock and both chains are left out. The flags then follow the exact occupancy in the same cycle. A sticky-free read error flag reports a read that was attempted while the FIFO was empty. This only happens when reading on empty is not permitted. Writes on full and reads on empty never move a pointer.

Top module: `dcfifo`

## Requirements
- R1: While `rst_ni` is low and after its release, `empty_o` and `aempty_o` are 1, `full_o`, `afull_o` and `rd_err_o` are 0, and `rd_data_o` is 0.
- R2: Data is read out in the order it was written. `rd_data_o` takes the oldest entry on the read clock edge that accepts a read (`rd_en_i` high and `empty_o` low), and it holds that value otherwise.
- R3: A write presented while `full_o` is high is dropped. No stored entry is overwritten, and later reads return only the entries accepted before.
- R4: A read presented while `empty_o` is high does not move the read pointer and leaves `rd_data_o` unchanged.
- R5: With `RD_EMPTY_OK` = 0, `rd_err_o` is 1 for exactly the read clock cycle after an edge where `rd_en_i` was high with `empty_o` high, and 0 otherwise. With `RD_EMPTY_OK` = 1 its value is unspecified.
- R6: `empty_o` is derived on the read clock from the write pointer after `WPTR_SYNC` read clock stages. After the first write into an empty FIFO, it stays high for `WPTR_SYNC` read clock edges, counting the write edge.
- R7: `full_o` is derived on the write clock from the read pointer after `RPTR_SYNC` write clock stages. After the first read from a full FIFO, it stays high for `RPTR_SYNC` write clock edges, counting the read edge.
- R8: `aempty_o` is high when the read-side occupancy is at most `AE_LEVEL`. `afull_o` is high when the write-side occupancy is at least `AF_LEVEL`. `full_o` implies `afull_o`, and `empty_o` implies `aempty_o`.
- R9: With `SINGLE_CLK` = 1, all four occupancy flags follow the exact occupancy in the cycle right after each edge, with no synchronizer lag.
- R10: Pointer values that cross between domains are Gray-coded and change in at most one bit per edge of their own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write clock (sole clock when `SINGLE_CLK` = 1) |
| rd_clk_i | input | 1 | Read clock, ignored when `SINGLE_CLK` = 1 |
| rst_ni | input | 1 | Active-low asynchronous reset for both sides |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered read data |
| empty_o | output | 1 | No entries visible to the read side |
| aempty_o | output | 1 | Read-side occupancy at or below `AE_LEVEL` |
| full_o | output | 1 | Write side sees `2**ADDR_W` entries |
| afull_o | output | 1 | Write-side occupancy at or above `AF_LEVEL` |
| rd_err_o | output | 1 | Read attempted while empty |

## Verification
Read data and the read error flag change on the read clock edge that takes the request, so they are due one cycle after it. An occupancy flag on the far side of a crossing moves only after its chain depth of further edges, three read edges for `empty_o` and two write edges for `full_o` in the bench. In single-clock mode every flag moves on the same edge. The bench keeps a behavioural model with a history of both pointer counts. It delays each count by the chain depth before forming the flags, updates the model at the clock edge, and compares every output at the following falling edge. Two explicit counts confirm the lags of R6 and R7 after the first write and the first read from full.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int PW = 32;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) ff_q[i] <= '0;
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int AW       = 3,
  parameter int AF_LEVEL = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rsync_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          we_o,
  output logic          full_o,
  output logic          afull_o
);
  localparam int DEPTH = 1 << AW;

  logic [AW:0]   wbin_q, wbin_d, rbin_s, occ;
  logic [PW-1:0] rs_full, wg_full;

  assign rs_full = gray2bin(PW'(rsync_i));
  assign rbin_s  = rs_full[AW:0];
  assign occ     = wbin_q - rbin_s;
  assign full_o  = occ[AW];
  assign afull_o = occ >= (AW+1)'(AF_LEVEL);
  assign we_o    = wr_en_i & ~full_o;
  assign wbin_d  = wbin_q + {{AW{1'b0}}, we_o};
  assign wg_full = bin2gray(PW'(wbin_d));
  assign waddr_o = wbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_o <= wg_full[AW:0];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> $stable(wbin_q)); // R3
  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= (AW+1)'(DEPTH)); // R3
  AST_WGRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wgray_o ^ $past(wgray_o))); // R10
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int AW          = 3,
  parameter int AE_LEVEL    = 2,
  parameter bit RD_EMPTY_OK = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW:0]   wsync_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          re_o,
  output logic          empty_o,
  output logic          aempty_o,
  output logic          rd_err_o
);
  logic [AW:0]   rbin_q, rbin_d, wbin_s, occ;
  logic [PW-1:0] ws_full, rg_full;

  assign ws_full  = gray2bin(PW'(wsync_i));
  assign wbin_s   = ws_full[AW:0];
  assign occ      = wbin_s - rbin_q;
  assign empty_o  = occ == '0;
  assign aempty_o = occ <= (AW+1)'(AE_LEVEL);
  assign re_o     = rd_en_i & ~empty_o;
  assign rbin_d   = rbin_q + {{AW{1'b0}}, re_o};
  assign rg_full  = bin2gray(PW'(rbin_d));
  assign raddr_o  = rbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_o  <= '0;
      rd_err_o <= 1'b0;
    end else begin
      rbin_q   <= rbin_d;
      rgray_o  <= rg_full[AW:0];
      rd_err_o <= !RD_EMPTY_OK && rd_en_i && empty_o;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> $stable(rbin_q)); // R4
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> $past(rd_en_i && empty_o)); // R5
  AST_RGRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rgray_o ^ $past(rgray_o))); // R10
endmodule

// File: rtl/dcfifo.sv
module dcfifo #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int WPTR_SYNC   = 3,
  parameter int RPTR_SYNC   = 2,
  parameter bit SINGLE_CLK  = 1'b0,
  parameter bit RD_EMPTY_OK = 1'b0,
  parameter int AE_LEVEL    = 2,
  parameter int AF_LEVEL    = 6
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              full_o,
  output logic              afull_o,
  output logic              rd_err_o
);
  logic              rclk, we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W:0]   wgray, rgray, wsync, rsync;

  assign rclk = SINGLE_CLK ? wr_clk_i : rd_clk_i;

  generate
    if (SINGLE_CLK) begin : g_direct
      assign wsync = wgray;
      assign rsync = rgray;
    end else begin : g_cross
      dcfifo_sync #(.W(ADDR_W+1), .STAGES(WPTR_SYNC)) u_wsync (
        .clk_i(rclk), .rst_ni(rst_ni), .d_i(wgray), .q_o(wsync));
      dcfifo_sync #(.W(ADDR_W+1), .STAGES(RPTR_SYNC)) u_rsync (
        .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rsync));
    end
  endgenerate

  dcfifo_wr_ctl #(.AW(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rsync_i(rsync),
    .waddr_o(waddr), .wgray_o(wgray), .we_o(we), .full_o(full_o), .afull_o(afull_o));

  dcfifo_rd_ctl #(.AW(ADDR_W), .AE_LEVEL(AE_LEVEL), .RD_EMPTY_OK(RD_EMPTY_OK)) u_rd (
    .clk_i(rclk), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .wsync_i(wsync),
    .raddr_o(raddr), .rgray_o(rgray), .re_o(re), .empty_o(empty_o),
    .aempty_o(aempty_o), .rd_err_o(rd_err_o));

  dcfifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk_i(wr_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rclk_i(rclk), .rst_ni(rst_ni), .re_i(re), .raddr_i(raddr), .rdata_o(rd_data_o));

  AST_FULL_AFULL: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    full_o |-> afull_o); // R8
  AST_EMPTY_AEMPTY: assert property (@(posedge rclk) disable iff (!rst_ni)
    empty_o |-> aempty_o); // R8
endmodule

// File: tb/dcfifo_test.sv
module dcfifo_test;
  localparam int CLK_P = 10;
  localparam int D     = 8;
  localparam int AE    = 2;
  localparam int AF    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data_a, rd_data_s;
  logic emp_a, aemp_a, ful_a, aful_a, err_a;
  logic emp_s, aemp_s, ful_s, aful_s, err_s;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dcfifo #(.DATA_W(8), .ADDR_W(3), .WPTR_SYNC(3), .RPTR_SYNC(2), .SINGLE_CLK(1'b0),
           .RD_EMPTY_OK(1'b0), .AE_LEVEL(AE), .AF_LEVEL(AF)) uut (
    .wr_clk_i(clk), .rd_clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data_a), .empty_o(emp_a), .aempty_o(aemp_a),
    .full_o(ful_a), .afull_o(aful_a), .rd_err_o(err_a));

  dcfifo #(.DATA_W(8), .ADDR_W(3), .WPTR_SYNC(2), .RPTR_SYNC(2), .SINGLE_CLK(1'b1),
           .RD_EMPTY_OK(1'b1), .AE_LEVEL(AE), .AF_LEVEL(AF)) uut_s (
    .wr_clk_i(clk), .rd_clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data_s), .empty_o(emp_s), .aempty_o(aemp_s),
    .full_o(ful_s), .afull_o(aful_s), .rd_err_o(err_s));

  // reference model: index 0 = crossing instance, 1 = single-clock instance
  int ws [2] = '{3, 0};
  int rs [2] = '{2, 0};
  int wc [2], rc [2], rq [2];
  int wh [2][8], rh [2][8], mm [2][D];
  bit rerr;

  function automatic int occ_r(int i); return wh[i][ws[i]] - rc[i]; endfunction
  function automatic int occ_w(int i); return wc[i] - rh[i][rs[i]]; endfunction

  task automatic model_update();
    for (int i = 0; i < 2; i++) begin
      bit e, f;
      e = occ_r(i) == 0;
      f = occ_w(i) == D;
      if (wr_en && !f) begin mm[i][wc[i] % D] = int'(wr_data); wc[i]++; end
      if (rd_en && !e) begin rq[i] = mm[i][rc[i] % D]; rc[i]++; end
      if (i == 0) rerr = rd_en && e;
      for (int k = 7; k > 0; k--) begin wh[i][k] = wh[i][k-1]; rh[i][k] = rh[i][k-1]; end
      wh[i][0] = wc[i];
      rh[i][0] = rc[i];
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R6", "async empty", int'(emp_a), int'(occ_r(0) == 0));
    chk("R8", "async aempty", int'(aemp_a), int'(occ_r(0) <= AE));
    chk("R7", "async full", int'(ful_a), int'(occ_w(0) == D));
    chk("R8", "async afull", int'(aful_a), int'(occ_w(0) >= AF));
    chk("R2", "async rd_data", int'(rd_data_a), rq[0]);
    chk("R5", "async rd_err", int'(err_a), int'(rerr));
    chk("R9", "sync empty", int'(emp_s), int'(occ_r(1) == 0));
    chk("R9", "sync aempty", int'(aemp_s), int'(occ_r(1) <= AE));
    chk("R9", "sync full", int'(ful_s), int'(occ_w(1) == D));
    chk("R9", "sync afull", int'(aful_s), int'(occ_w(1) >= AF));
    chk("R2", "sync rd_data", int'(rd_data_s), rq[1]);
  endtask

  task automatic step(bit we, bit re, logic [7:0] d);
    wr_en = we; rd_en = re; wr_data = d;
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cnt_a, cnt_s;
    for (int i = 0; i < 2; i++) begin
      wc[i] = 0; rc[i] = 0; rq[i] = 0;
      for (int k = 0; k < 8; k++) begin wh[i][k] = 0; rh[i][k] = 0; end
    end
    rerr = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset empty/aempty", int'({emp_a, aemp_a, emp_s, aemp_s}), 15);
    chk("R1", "reset full/afull/err", int'({ful_a, aful_a, err_a, ful_s, aful_s}), 0);
    chk("R1", "reset rd_data", int'(rd_data_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R6: empty lag after first write
    cnt_a = 0; cnt_s = 0;
    step(1, 0, 8'hA5);
    cnt_a += int'(emp_a); cnt_s += int'(emp_s);
    for (int k = 0; k < 5; k++) begin
      step(0, 0, 8'h00);
      cnt_a += int'(emp_a); cnt_s += int'(emp_s);
    end
    chk("R6", "empty high edges after first write", cnt_a, 3);
    chk("R9", "sync empty high edges after first write", cnt_s, 0);
    step(0, 1, 8'h00);
    step(0, 0, 8'h00);
    chk("R2", "single entry read", int'(rd_data_a), 8'hA5);

    // fill past capacity
    for (int k = 0; k < 11; k++) step(1, 0, 8'(8'h10 + k));
    repeat (4) step(0, 0, 8'h00);
    chk("R3", "full after overfill", int'({ful_a, ful_s}), 3);

    // R7: full lag after first read
    cnt_a = 0; cnt_s = 0;
    for (int k = 0; k < 8; k++) begin
      step(0, 1, 8'h00);
      cnt_a += int'(ful_a); cnt_s += int'(ful_s);
    end
    chk("R7", "full high edges after first read", cnt_a, 2);
    chk("R9", "sync full high edges after first read", cnt_s, 0);
    step(0, 0, 8'h00);
    chk("R3", "last entry is eighth write", int'(rd_data_a), 8'h17);
    chk("R3", "sync last entry is eighth write", int'(rd_data_s), 8'h17);
    chk("R2", "empty after drain", int'({emp_a, emp_s}), 3);

    // R4/R5: read while empty
    step(0, 1, 8'h00);
    chk("R5", "rd_err after read on empty", int'(err_a), 1);
    chk("R4", "rd_data held on empty read", int'(rd_data_a), 8'h17);
    chk("R4", "sync rd_data held on empty read", int'(rd_data_s), 8'h17);
    step(0, 0, 8'h00);
    chk("R5", "rd_err clears", int'(err_a), 0);

    // mixed traffic, write-heavy then read-heavy then balanced
    for (int k = 0; k < 200; k++) step(($urandom % 4) != 0, ($urandom % 4) == 0, 8'($urandom));
    for (int k = 0; k < 200; k++) step(($urandom % 4) == 0, ($urandom % 4) != 0, 8'($urandom));
    for (int k = 0; k < 400; k++) step(1'($urandom), 1'($urandom), 8'($urandom));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule